// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned integer by another over a fixed number of clock cycles. A caller presents a dividend and a divisor together with a one-cycle start pulse. The block then settles one quotient bit per cycle. Each step adds the divisor to the running partial remainder or subtracts it, and the sign of that partial remainder picks which. A wrong guess is never undone. One extra cycle at the end brings a negative final partial remainder back into range. After that the quotient, the remainder and a ready flag appear.

The datapath is a single adder/subtractor plus shifting. No multiplier is used. The partial remainder carries one bit more than the divisor so that its sign can be tested. The dividend register also collects the quotient: as each dividend bit leaves at the top, the new quotient bit enters at the bottom. A zero divisor needs no special path. The same recurrence yields an all-ones quotient and returns the dividend as the remainder, with the normal latency.

Top module: `nrdiv_seq`

## Requirements
- R1: After reset, `ready` is 0 and both `quotient` and `remainder` are 0.
- R2: A start pulse is accepted at a clock edge when the block is idle or showing a result (`ready` high). At that edge `dividend` and `divisor` are captured, and `ready` is 0 after that edge.
- R3: `ready` stays 0 for the 16 edges that follow the accepting edge. It becomes 1 at the 17th edge after the accepting edge.
- R4: For any nonzero divisor, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor. For example, 32768 / 158 gives 207 remainder 62.
- R5: When the divisor is nonzero, the result shows a `remainder` strictly less than the divisor, including for cases where the final partial remainder was negative before correction.
- R6: A zero divisor gives `quotient` = 16'hFFFF and `remainder` = dividend, with the same 17-cycle latency as any other operand pair.
- R7: A start pulse while a division is in progress (between the accepting edge and the edge that raises `ready`) is ignored. The running division finishes with its original operands at its original time.
- R8: `quotient` and `remainder` keep their previous values while a division is in progress. Once `ready` is 1, it stays 1 with both outputs unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin a division with the present operands |
| dividend | input | 16 | Unsigned dividend, sampled at the accepting edge |
| divisor | input | 16 | Unsigned divisor, sampled at the accepting edge |
| quotient | output | 16 | Integer quotient of the last finished division |
| remainder | output | 16 | Remainder of the last finished division |
| ready | output | 1 | High while a finished result is presented |

## Verification
Results are due exactly 17 rising edges after the edge that accepts the start pulse. Until then `ready` is due low at every one of the 16 edges in between. The bench samples at the falling edge after each rising edge and counts those edges from the accepting one. It therefore checks `ready` low after edges 0 to 16 and checks the values after edge 17, never a cycle early or late. A start poked in mid-run is placed before a known edge, so the result is still checked at the original edge 17, against the original operands.

// File: rtl/nrdiv_pkg.sv
package nrdiv_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ITER = 2'd1,
        PH_FIX  = 2'd2,
        PH_DONE = 2'd3
    } phase_e;

endpackage

// File: rtl/nrdiv_ctrl.sv
module nrdiv_ctrl
    import nrdiv_pkg::*;
#(
    parameter int STEPS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic load,
    output logic iter,
    output logic fix,
    output logic done
);

    localparam int CW = $clog2(STEPS + 1);
    localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

    typedef struct packed {
        phase_e          phase;
        logic [CW-1:0]   cnt;
    } ctrl_s;

    ctrl_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        load = start && (st_q.phase == PH_IDLE || st_q.phase == PH_DONE);
        unique case (st_q.phase)
            PH_IDLE, PH_DONE: begin
                if (load) begin
                    st_d.phase = PH_ITER;
                    st_d.cnt   = '0;
                end
            end
            PH_ITER: begin
                if (st_q.cnt == LAST) begin
                    st_d.phase = PH_FIX;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            PH_FIX: begin
                st_d.phase = PH_DONE;
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_IDLE;
            st_q.cnt   <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign iter = (st_q.phase == PH_ITER);
    assign fix  = (st_q.phase == PH_FIX);
    assign done = (st_q.phase == PH_DONE);

    AST_LAST_STEP_TO_FIX: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ITER && st_q.cnt == LAST) |=> (st_q.phase == PH_FIX)); // R3
    AST_FIX_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_FIX) |=> done); // R3
    AST_STEP_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.phase == PH_ITER && st_q.cnt != LAST) |=> (iter && st_q.cnt == $past(st_q.cnt) + 1'b1)); // R7

endmodule

// File: rtl/nrdiv_step.sv
module nrdiv_step #(
    parameter int W = 16
) (
    input  logic [W:0]   prem,
    input  logic         nbit,
    input  logic [W-1:0] dvs,
    output logic [W:0]   prem_nx,
    output logic         qbit
);

    logic [W:0] shifted;
    logic [W:0] dvs_ext;

    always_comb begin
        shifted = {prem[W-1:0], nbit};
        dvs_ext = {1'b0, dvs};
        if (prem[W]) begin
            prem_nx = shifted + dvs_ext;
        end else begin
            prem_nx = shifted - dvs_ext;
        end
        qbit = ~prem_nx[W];
    end

endmodule

// File: rtl/nrdiv_fix.sv
module nrdiv_fix #(
    parameter int W = 16
) (
    input  logic [W:0]   prem,
    input  logic [W-1:0] dvs,
    output logic [W-1:0] rem
);

    always_comb begin
        if (prem[W]) begin
            rem = prem[W-1:0] + dvs;
        end else begin
            rem = prem[W-1:0];
        end
    end

endmodule

// File: rtl/nrdiv_seq.sv
module nrdiv_seq #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic [W-1:0] remainder,
    output logic         ready
);

    typedef struct packed {
        logic [W:0]   prem;
        logic [W-1:0] acc;
        logic [W-1:0] dvs;
        logic [W-1:0] quo;
        logic [W-1:0] rem;
    } dp_s;

    dp_s dp_d, dp_q;

    logic         load, iter, fix, done;
    logic [W:0]   step_nx;
    logic         step_q;
    logic [W-1:0] fix_rem;

    nrdiv_ctrl #(.STEPS(W)) i_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .load  (load),
        .iter  (iter),
        .fix   (fix),
        .done  (done)
    );

    nrdiv_step #(.W(W)) i_step (
        .prem    (dp_q.prem),
        .nbit    (dp_q.acc[W-1]),
        .dvs     (dp_q.dvs),
        .prem_nx (step_nx),
        .qbit    (step_q)
    );

    nrdiv_fix #(.W(W)) i_fix (
        .prem (dp_q.prem),
        .dvs  (dp_q.dvs),
        .rem  (fix_rem)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.prem = '0;
            dp_d.acc  = dividend;
            dp_d.dvs  = divisor;
        end
        if (iter) begin
            dp_d.prem = step_nx;
            dp_d.acc  = {dp_q.acc[W-2:0], step_q};
        end
        if (fix) begin
            dp_d.quo = dp_q.acc;
            dp_d.rem = fix_rem;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dp_q <= '0;
        end else begin
            dp_q <= dp_d;
        end
    end

    assign quotient  = dp_q.quo;
    assign remainder = dp_q.rem;
    assign ready     = done;

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !ready); // R2
    AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && dp_q.dvs != '0) |-> (remainder < dp_q.dvs)); // R5
    AST_ZERO_DIV_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && dp_q.dvs == '0) |-> (quotient == '1)); // R6
    AST_BUSY_KEEPS_OPERAND: assert property (@(posedge clk) disable iff (!rst_n)
        (iter || fix) |=> $stable(dp_q.dvs)); // R7
    AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> (ready && $stable(quotient) && $stable(remainder))); // R8
    AST_BUSY_OUTPUTS_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        iter |=> ($stable(quotient) && $stable(remainder))); // R8

endmodule

// File: tb/test_nrdiv_seq.sv
`timescale 1ns/1ps
module test_nrdiv_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic [15:0] quotient;
    logic [15:0] remainder;
    logic        ready;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    always #4 clk = ~clk;

    nrdiv_seq #(.W(16)) i_nrdiv_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder),
        .ready     (ready)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x;
        x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic run_op(input logic [15:0] a, input logic [15:0] b, input bit poke);
        logic [15:0] eq, er, pq, pr;
        bit busy_ok;
        if (b == 16'd0) begin
            eq = 16'hFFFF;
            er = a;
        end else begin
            eq = a / b;
            er = a % b;
        end
        pq = quotient;
        pr = remainder;
        @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(ready == 1'b0, "R2", "ready after accept", ready, 0);
        busy_ok = 1'b1;
        for (int i = 1; i <= 16; i++) begin
            if (poke && i == 5) begin
                start    = 1'b1;
                dividend = ~a;
                divisor  = b ^ 16'h5A5A;
            end
            @(negedge clk);
            start = 1'b0;
            if (ready !== 1'b0 || quotient !== pq || remainder !== pr) busy_ok = 1'b0;
        end
        chk(busy_ok, "R3", "ready low and outputs held during run (R8)", busy_ok, 1);
        @(negedge clk);
        chk(ready == 1'b1, "R3", "ready at edge 17", ready, 1);
        if (b == 16'd0) begin
            chk(quotient == eq, "R6", "zero-divisor quotient", quotient, eq);
            chk(remainder == er, "R6", "zero-divisor remainder", remainder, er);
        end else begin
            chk(quotient == eq, poke ? "R7" : "R4", "quotient", quotient, eq);
            chk(remainder == er, poke ? "R7" : "R5", "remainder", remainder, er);
        end
    endtask

    task automatic hold_check(input int n);
        logic [15:0] hq, hr;
        bit ok;
        hq = quotient;
        hr = remainder;
        ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (ready !== 1'b1 || quotient !== hq || remainder !== hr) ok = 1'b0;
        end
        chk(ok, "R8", "result held while idle", ok, 1);
    endtask

    initial begin
        logic [15:0] dl [12];
        dl = '{16'd1, 16'd2, 16'd3, 16'd7, 16'd158, 16'd255, 16'd256,
               16'd4095, 16'd32767, 16'd32768, 16'd65534, 16'd65535};
        repeat (3) @(negedge clk);
        chk(ready == 1'b0, "R1", "ready in reset", ready, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ready == 1'b0 && quotient == 16'd0 && remainder == 16'd0, "R1",
            "outputs after reset", {ready, quotient, remainder}, 0);

        run_op(16'd32768, 16'd158, 1'b0);
        chk(quotient == 16'd207 && remainder == 16'd62, "R4", "32768/158",
            {quotient, remainder}, {16'd207, 16'd62});
        hold_check(6);

        run_op(16'd1000, 16'd0, 1'b0);
        run_op(16'hFFFF, 16'd0, 1'b0);
        run_op(16'd0, 16'd0, 1'b0);
        hold_check(3);

        run_op(16'd40000, 16'd123, 1'b1);
        run_op(16'd77, 16'd1000, 1'b1);

        foreach (dl[j]) begin
            run_op(16'd0, dl[j], 1'b0);
            run_op(16'hFFFF, dl[j], 1'b0);
            run_op(dl[j], dl[j], 1'b0);
            run_op(dl[j] - 16'd1, dl[j], 1'b0);
            run_op(16'h8000, dl[j], 1'b0);
        end

        for (int k = 0; k < 1500; k++) begin
            seed = nxt(seed);
            if (k % 4 == 0) run_op(seed[31:16], {8'd0, seed[7:0]}, k % 50 == 1);
            else            run_op(seed[31:16], seed[15:0], k % 50 == 1);
        end

        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule